// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block keeps a short queue of instruction bytes filled ahead of an execution unit. A fetch engine reads memory from a running fetch address on its own schedule. Each read is a two-byte word at an even address, or a single byte at an odd address so that the address becomes even again. Returned bytes go on at the tail of the queue. The consumer sees up to six head bytes and how many of them are valid. Each cycle it removes however many bytes its current instruction needs. Fetching and consumption overlap, so bytes are usually waiting before they are asked for.

When the execution side changes the instruction flow, it raises a redirect with a target address. Every queued byte is discarded and fetching restarts at the target. A read whose response has not come back yet is marked stale, and its data never reaches the queue. The fetch engine is a three-state machine. In ISSUE it may place a read. In WAIT one read is outstanding. In DROP the outstanding read became stale because of a redirect and the engine waits for it to return. The transitions are ISSUE to WAIT when a read is accepted, WAIT to ISSUE on a response, WAIT to DROP on a redirect with no response in that cycle, WAIT to ISSUE on a redirect that coincides with the response, and DROP to ISSUE when the stale response arrives.

Top module: `pfq_prefetch_queue`

## Requirements
- R1: After reset the valid count is 0, all head bytes read 0, and the first read is requested at the parameter `RESET_ADDR`.
- R2: A read is requested only in ISSUE and only without a redirect that cycle. It is two bytes wide (`mem_req_wide`=1) at an even address and one byte wide (`mem_req_wide`=0) at an odd address. The fetch address then advances by the read size. At most one read is outstanding, and the request holds its address until it is accepted.
- R3: For a response, `mem_rsp_data[7:0]` is the byte at the request address and `mem_rsp_data[15:8]` is the byte at the next address (two-byte reads only). The bytes are appended behind the valid bytes and are visible in the next cycle.
- R4: Head byte i (i=0 oldest) sits on `head_bytes[8i+7:8i]`. Positions at or above `head_count` read 0, and `head_count` never exceeds 6.
- R5: A `take_cnt` no larger than `head_count` removes that many bytes from the head in the next cycle, and the remaining bytes move down to position 0. A take of 0 removes nothing.
- R6: A `take_cnt` larger than `head_count` raises `take_err` in the same cycle and removes no bytes.
- R7: A redirect empties the queue in the next cycle, whatever the take in the same cycle. The next read starts at `redir_addr`, sized by its parity.
- R8: A response to a read accepted before a redirect is never written into the queue, whether it arrives in the redirect cycle or later.
- R9: A read is requested only when free space (6 minus `head_count`) is at least its size. When the engine is in ISSUE with enough room and no redirect, the request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Read byte address |
| mem_req_wide | output | 1 | 1: two-byte read, 0: one-byte read |
| mem_rsp_valid | input | 1 | Read data returned (in order, one per accepted read) |
| mem_rsp_data | input | 16 | Read data, low byte at the request address |
| head_bytes | output | 8*QDEPTH | Head bytes, byte 0 oldest |
| head_count | output | CW | Number of valid head bytes |
| take_cnt | input | CW | Bytes to remove this cycle |
| take_err | output | 1 | Take larger than the valid count, ignored |
| redir_valid | input | 1 | Flush the queue and restart fetching |
| redir_addr | input | AW | New fetch address |

## Verification
The bench sweeps take sizes from 0 to 7 against every fill level. It covers response latencies from zero to three cycles and both accepting and stalling memory, and it compares every head byte with a closed-form memory pattern at the expected address. Redirects are placed at each distance from an accepted read, to even and odd targets, and together with takes. A design that let a stale response into the queue would show bytes from the old address or a wrong count. A design that ignored parity would request a two-byte read at an odd target. The full-queue and oversized-take corners catch a design that fetched without room, and one that wrapped the count instead of refusing the take.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    typedef enum logic [1:0] {
        FS_ISSUE = 2'd0,
        FS_WAIT  = 2'd1,
        FS_DROP  = 2'd2
    } fetch_state_t;
endpackage

// File: rtl/pfq_fetch_fsm.sv
module pfq_fetch_fsm
    import pfq_pkg::*;
#(
    parameter int AW = 16,
    parameter int QDEPTH = 6,
    parameter logic [AW-1:0] RESET_ADDR = '0,
    localparam int CW = $clog2(QDEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] fill,
    input  logic          redir_valid,
    input  logic [AW-1:0] redir_addr,
    input  logic          req_ready,
    input  logic          rsp_valid,
    output logic          req_valid,
    output logic [AW-1:0] req_addr,
    output logic          req_wide,
    output logic          wr_en,
    output logic          wr_two
);
    fetch_state_t state_q, state_d;
    logic [AW-1:0] fetch_q;
    logic          wide_q;
    logic [CW:0]   room;
    logic [CW:0]   need;
    logic          accept;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_ISSUE;
        else        state_q <= state_d;
    end

    // fetch address and size of the outstanding read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_q <= RESET_ADDR;
            wide_q  <= 1'b0;
        end else if (redir_valid) begin
            fetch_q <= redir_addr;
        end else if (accept) begin
            fetch_q <= fetch_q + AW'(need);
            wide_q  <= req_wide;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_ISSUE: if (accept) state_d = FS_WAIT;
            FS_WAIT: begin
                if (redir_valid)    state_d = rsp_valid ? FS_ISSUE : FS_DROP;
                else if (rsp_valid) state_d = FS_ISSUE;
            end
            FS_DROP:  if (rsp_valid) state_d = FS_ISSUE;
            default:  state_d = FS_ISSUE;
        endcase
    end

    // outputs
    always_comb begin
        room      = (CW+1)'(QDEPTH) - {1'b0, fill};
        need      = fetch_q[0] ? (CW+1)'(1) : (CW+1)'(2);
        req_addr  = fetch_q;
        req_wide  = ~fetch_q[0];
        req_valid = 1'b0;
        wr_en     = 1'b0;
        wr_two    = wide_q;
        unique case (state_q)
            FS_ISSUE: req_valid = !redir_valid && (room >= need);
            FS_WAIT:  wr_en     = rsp_valid && !redir_valid;
            FS_DROP:  wr_en     = 1'b0;
            default:  req_valid = 1'b0;
        endcase
        accept = req_valid && req_ready;
    end

    // R2: a response is only legal while a read is outstanding
    assert_rsp_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (state_q != FS_ISSUE));

    // R2: a stalled request keeps its address unless a redirect cancels it
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> ((req_valid && $stable(req_addr)) || redir_valid));

    // R8: nothing is written in the cycle after a stale read was marked
    assert_stale_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_DROP) |-> !wr_en);
endmodule

// File: rtl/pfq_byte_store.sv
module pfq_byte_store #(
    parameter int QDEPTH = 6,
    localparam int CW = $clog2(QDEPTH + 1),
    localparam int DW = 8 * QDEPTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [CW-1:0] take_cnt,
    input  logic          wr_en,
    input  logic          wr_two,
    input  logic [15:0]   wr_data,
    output logic [DW-1:0] bytes,
    output logic [CW-1:0] count,
    output logic          take_err
);
    logic [DW-1:0] data_q, data_d, shifted;
    logic [CW-1:0] count_q, count_d;
    logic [CW-1:0] take_eff, base, add_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            count_q <= '0;
        end else begin
            data_q  <= data_d;
            count_q <= count_d;
        end
    end

    always_comb begin
        take_err = take_cnt > count_q;
        take_eff = take_err ? '0 : take_cnt;
        base     = count_q - take_eff;
        add_n    = wr_en ? (wr_two ? CW'(2) : CW'(1)) : '0;
        shifted  = data_q >> {take_eff, 3'b000};
        data_d   = shifted;
        for (int i = 0; i < QDEPTH; i++) begin
            if (wr_en && (CW'(i) == base))
                data_d[8*i +: 8] = wr_data[7:0];
            if (wr_en && wr_two && (CW'(i) == base + CW'(1)))
                data_d[8*i +: 8] = wr_data[15:8];
        end
        count_d = base + add_n;
        if (flush) begin
            data_d  = '0;
            count_d = '0;
        end
    end

    assign bytes = data_q;
    assign count = count_q;

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((CW+1)'(base) + (CW+1)'(add_n) <= (CW+1)'(QDEPTH)));

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(QDEPTH));

    assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count_q == '0) && (data_q == '0));

    assert_take_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !wr_en && (take_cnt <= count_q)) |=>
            (count_q == $past(count_q) - $past(take_cnt)));

    assert_bad_take_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !wr_en && (take_cnt > count_q)) |=> $stable(count_q));
endmodule

// File: rtl/pfq_prefetch_queue.sv
module pfq_prefetch_queue #(
    parameter int AW = 16,
    parameter int QDEPTH = 6,
    parameter logic [AW-1:0] RESET_ADDR = 16'h1FFE,
    localparam int CW = $clog2(QDEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [AW-1:0]       mem_req_addr,
    output logic                mem_req_wide,
    input  logic                mem_rsp_valid,
    input  logic [15:0]         mem_rsp_data,
    output logic [8*QDEPTH-1:0] head_bytes,
    output logic [CW-1:0]       head_count,
    input  logic [CW-1:0]       take_cnt,
    output logic                take_err,
    input  logic                redir_valid,
    input  logic [AW-1:0]       redir_addr
);
    logic          wr_en;
    logic          wr_two;
    logic [CW-1:0] fill;

    pfq_fetch_fsm #(
        .AW(AW), .QDEPTH(QDEPTH), .RESET_ADDR(RESET_ADDR)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .fill(fill),
        .redir_valid(redir_valid), .redir_addr(redir_addr),
        .req_ready(mem_req_ready), .rsp_valid(mem_rsp_valid),
        .req_valid(mem_req_valid), .req_addr(mem_req_addr),
        .req_wide(mem_req_wide), .wr_en(wr_en), .wr_two(wr_two)
    );

    pfq_byte_store #(.QDEPTH(QDEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(redir_valid),
        .take_cnt(take_cnt), .wr_en(wr_en), .wr_two(wr_two),
        .wr_data(mem_rsp_data), .bytes(head_bytes),
        .count(fill), .take_err(take_err)
    );

    assign head_count = fill;

    // R2: odd fetch addresses are read one byte wide
    assert_odd_narrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_addr[0]) |-> !mem_req_wide);
endmodule

// File: tb/pfq_prefetch_queue_test.sv
module pfq_prefetch_queue_test;
    localparam int QD = 6;
    localparam int AW = 16;
    localparam int CW = 3;
    localparam logic [15:0] RST_A = 16'h1FFE;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [AW-1:0]     mem_req_addr;
    logic              mem_req_wide;
    logic              mem_rsp_valid = 1'b0;
    logic [15:0]       mem_rsp_data = '0;
    logic [8*QD-1:0]   head_bytes;
    logic [CW-1:0]     head_count;
    logic [CW-1:0]     take_cnt = '0;
    logic              take_err;
    logic              redir_valid = 1'b0;
    logic [AW-1:0]     redir_addr = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model
    int          ecount;
    logic [15:0] head_a, efetch, p_addr;
    bit          pend, stale, p_wide;
    int          p_delay;

    always #4 clk = ~clk;

    pfq_prefetch_queue #(.AW(AW), .QDEPTH(QD), .RESET_ADDR(RST_A)) uut (
        .clk(clk), .rst_n(rst_n),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_wide(mem_req_wide),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .head_bytes(head_bytes), .head_count(head_count),
        .take_cnt(take_cnt), .take_err(take_err),
        .redir_valid(redir_valid), .redir_addr(redir_addr)
    );

    function automatic logic [7:0] mbyte(logic [15:0] a);
        return (a[7:0] * 8'd13) ^ (a[15:8] + 8'h5B);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cycle(int take, bit rd, logic [15:0] ta, bit rdy, int lat);
        bit fire, hs, exp_req;
        int need;
        @(negedge clk);
        take_cnt      = CW'(take);
        redir_valid   = rd;
        redir_addr    = ta;
        mem_req_ready = rdy;
        fire          = pend && (p_delay == 0);
        mem_rsp_valid = fire;
        mem_rsp_data  = fire ? {(p_wide ? mbyte(p_addr + 16'd1) : 8'hEE), mbyte(p_addr)} : 16'h0;
        #1;
        check(int'(head_count) == ecount, "R5/R7", "head_count", head_count, ecount);
        check(head_count <= 3'(QD), "R4", "count bound", head_count, QD);
        for (int i = 0; i < QD; i++) begin
            if (i < ecount)
                check(head_bytes[8*i +: 8] == mbyte(head_a + 16'(i)), "R3/R8", "head byte",
                      head_bytes[8*i +: 8], mbyte(head_a + 16'(i)));
            else
                check(head_bytes[8*i +: 8] == 8'h00, "R4", "empty byte", head_bytes[8*i +: 8], 0);
        end
        check(take_err == (take > ecount), "R6", "take_err", take_err, take > ecount);
        need    = efetch[0] ? 1 : 2;
        exp_req = !pend && !rd && ((QD - ecount) >= need);
        check(mem_req_valid == exp_req, "R2/R9", "req_valid", mem_req_valid, exp_req);
        if (mem_req_valid) begin
            check(mem_req_addr == efetch, "R2", "req_addr", mem_req_addr, efetch);
            check(mem_req_wide == !efetch[0], "R2", "req_wide", mem_req_wide, !efetch[0]);
        end
        hs = mem_req_valid && rdy;
        @(posedge clk);
        if (rd) begin
            ecount = 0; head_a = ta; efetch = ta;
            if (pend && !fire) stale = 1;
        end else begin
            if (take <= ecount) begin ecount -= take; head_a += 16'(take); end
            if (fire && !stale) ecount += p_wide ? 2 : 1;
        end
        if (fire) begin pend = 0; stale = 0; end
        else if (pend) p_delay--;
        if (hs) begin
            pend = 1; p_addr = efetch; p_wide = !efetch[0]; p_delay = lat;
            efetch += 16'(need);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        ecount = 0; head_a = RST_A; efetch = RST_A;
        pend = 0; stale = 0; p_wide = 0; p_delay = 0; p_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(head_count == 3'd0, "R1", "reset count", head_count, 0);
        check(head_bytes == '0, "R1", "reset bytes", int'(head_bytes[31:0]), 0);
        check(mem_req_valid && mem_req_addr == RST_A, "R1", "reset fetch addr", mem_req_addr, RST_A);

        // R9/R5/R6: fill to full, then every take size per latency
        for (int lat = 0; lat < 4; lat++) begin
            repeat (10) cycle(0, 0, 16'h0, 1, lat);
            for (int t = 0; t < 8; t++) begin
                cycle(t, 0, 16'h0, 1, lat);
                repeat (4) cycle(0, 0, 16'h0, 1, lat);
            end
        end

        // R5/R3: steady consumption with stalling memory
        for (int lat = 0; lat < 3; lat++)
            for (int t = 1; t < 5; t++)
                for (int k = 0; k < 30; k++)
                    cycle((k % 3 == 2) ? 0 : t, 0, 16'h0, (k % 2) == 0, lat);

        // R7/R8: redirect at each distance from an accepted read, both parities, with a take
        for (int k = 0; k < 6; k++)
            for (int par = 0; par < 2; par++) begin
                repeat (k) cycle(1, 0, 16'h0, 1, 3);
                cycle(2, 1, 16'h4000 + 16'(k * 16 + par), 1, 3);
                repeat (10) cycle(0, 0, 16'h0, 1, 1);
                cycle(3, 0, 16'h0, 1, 0);
            end

        // R7/R2: redirect while a request is stalled, and back-to-back redirects
        repeat (3) cycle(0, 0, 16'h0, 0, 0);
        cycle(0, 1, 16'h7001, 0, 0);
        cycle(0, 1, 16'h7FFF, 1, 0);
        repeat (8) cycle(1, 0, 16'h0, 1, 0);
        cycle(7, 1, 16'h8002, 1, 2);
        repeat (8) cycle(0, 0, 16'h0, 1, 2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule